// File: doc/BRIEF.md
# Dual-Path Registered Bus Transceiver

This block moves an 18-bit word from an A side to a B side and another from B to A. The two directions are fully independent. Each direction has one storage word and three controls: a latch enable, a path clock and an output enable. A high latch enable makes the path transparent, so the output tracks the input within the same cycle. With the latch enable low, the word is held. A fresh word is taken only when the path clock falls.

All controls are sampled by a free-running system clock. A path-clock fall is seen when the previous sample was high and the current sample is low. The stored word is then written at that system-clock edge. Each port gives out data plus one drive-enable bit, so the surrounding logic can steer a tri-state pad or a multiplexer. The two output enables have opposite polarity. A synchronous active-high reset clears both stored words and the path-clock history.

Top module: `xcvr_bidir`

## Requirements
- R1: While a path's latch enable is 1, that path's output equals its input in the same cycle (A to B: `b_out == a_in`; B to A: `a_out == b_in`).
- R2: While the latch enable is 0 and no path-clock fall is sampled, the output stays unchanged from cycle to cycle, whatever the input does.
- R3: With the latch enable 0, a path-clock fall (sampled 1 at one system-clock edge, then 0 at the next) loads the input present at the second edge. That word appears on the output from the following cycle on.
- R4: A rising path clock loads nothing. The output keeps its old word.
- R5: When the latch enable drops from 1 to 0 with no path-clock fall, the output keeps the last word that passed through while the path was transparent.
- R6: `b_drive` is 1 exactly when `ab_oe` is 1 (active high).
- R7: `a_drive` is 1 exactly when `ba_oe_n` is 0 (active low).
- R8: The controls and data of one direction have no effect on the output or drive of the other direction.
- R9: A cycle with `rst` at 1 clears both stored words to zero and clears the path-clock history. A path clock held at 0 just after reset is therefore not taken as a fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all controls |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | A-side data, source of the A-to-B path |
| b_in | input | 18 | B-side data, source of the B-to-A path |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_clk | input | 1 | A-to-B path clock; a fall loads the word |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_clk | input | 1 | B-to-A path clock; a fall loads the word |
| b_out | output | 18 | Data for the B side |
| b_drive | output | 1 | 1 when the B side is driven |
| a_out | output | 18 | Data for the A side |
| a_drive | output | 1 | 1 when the A side is driven |

## Verification
The bench targets five weak spots:

- **Load timing.** The cycle just after a path-clock fall must already show the new word, while the fall cycle itself still shows the old one. A design that loads one edge late, or on the rising edge, shows the wrong word in one of these two cycles.
- **Closing the latch.** When the latch closes, the output must keep the last transparent word. A design that clears or reloads the store here produces a changed value.
- **Reset history.** A design that does not clear the clock history after reset sees a false fall and loads an unexpected word.
- **Enable polarity.** A swapped polarity on either enable shows up at once as a wrong drive bit.
- **Path independence.** Toggling one path's controls while the other path holds exposes any cross-coupling between the two directions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    parameter int unsigned XCVR_W = 18;

    // Per-path control bundle as seen at the block edge
    typedef struct packed {
        logic oe_raw;   // enable in the path's own polarity
        logic le;       // 1 = transparent
        logic pclk;     // path clock level
    } lane_ctl_t;

    // Fall of the path clock between two system-clock samples
    function automatic logic is_fall(input logic prev_lvl, input logic cur_lvl);
        return prev_lvl & ~cur_lvl;
    endfunction

endpackage

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic fall
);
    import xcvr_pkg::*;

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign fall = is_fall(prev_q, lvl);
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int unsigned W = xcvr_pkg::XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic         fall,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] word_q;
    logic         load;

    // Transparent phase tracks the input so closing keeps the last word
    assign load = le | fall;

    always_ff @(posedge clk) begin
        if (rst)       word_q <= '0;
        else if (load) word_q <= din;
    end

    assign dout = le ? din : word_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int unsigned W      = xcvr_pkg::XCVR_W,
    parameter bit          OE_LOW = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  xcvr_pkg::lane_ctl_t ctl,
    input  logic [W-1:0]        din,
    output logic [W-1:0]        dout,
    output logic                drive
);
    logic fall;

    xcvr_fall_det u_fall (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ctl.pclk),
        .fall (fall)
    );

    xcvr_store #(.W(W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .le   (ctl.le),
        .fall (fall),
        .din  (din),
        .dout (dout)
    );

    generate
        if (OE_LOW) begin : g_oe_low
            assign drive = ~ctl.oe_raw;
        end else begin : g_oe_high
            assign drive = ctl.oe_raw;
        end
    endgenerate
endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir #(
    parameter int unsigned W = xcvr_pkg::XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_oe,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_clk,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    output logic [W-1:0] a_out,
    output logic         a_drive
);
    import xcvr_pkg::*;

    lane_ctl_t ctl_ab, ctl_ba;

    assign ctl_ab = '{oe_raw: ab_oe,   le: ab_le, pclk: ab_clk};
    assign ctl_ba = '{oe_raw: ba_oe_n, le: ba_le, pclk: ba_clk};

    xcvr_lane #(.W(W), .OE_LOW(1'b0)) u_ab (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl_ab),
        .din   (a_in),
        .dout  (b_out),
        .drive (b_drive)
    );

    xcvr_lane #(.W(W), .OE_LOW(1'b1)) u_ba (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl_ba),
        .din   (b_in),
        .dout  (a_out),
        .drive (a_drive)
    );
endmodule

// File: rtl/xcvr_bidir_chk.sv
module xcvr_bidir_chk #(
    parameter int unsigned W = xcvr_pkg::XCVR_W
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_oe,
    input logic         ab_le,
    input logic         ab_clk,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_clk,
    input logic [W-1:0] b_out,
    input logic         b_drive,
    input logic [W-1:0] a_out,
    input logic         a_drive
);
    // One cycle clear of reset, so $past of the path clock is a real sample
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_ab_transparent_R1: assert property (@(posedge clk) disable iff (rst)
        ab_le |-> (b_out == a_in));
    assert_ba_transparent_R1: assert property (@(posedge clk) disable iff (rst)
        ba_le |-> (a_out == b_in));

    assert_ab_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (armed && !ab_le && !($past(ab_clk) && !ab_clk)) |=> (ab_le || $stable(b_out)));
    assert_ba_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (armed && !ba_le && !($past(ba_clk) && !ba_clk)) |=> (ba_le || $stable(a_out)));

    assert_ab_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && !ab_le && $past(ab_clk) && !ab_clk) |=> (ab_le || b_out == $past(a_in)));
    assert_ba_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && !ba_le && $past(ba_clk) && !ba_clk) |=> (ba_le || a_out == $past(b_in)));

    assert_ab_close_R5: assert property (@(posedge clk) disable iff (rst)
        (ab_le && !ab_clk) |=> (ab_le || b_out == $past(a_in)));

    assert_b_drive_R6: assert property (@(posedge clk) disable iff (rst)
        b_drive == ab_oe);
    assert_a_drive_R7: assert property (@(posedge clk) disable iff (rst)
        a_drive == !ba_oe_n);
endmodule

bind xcvr_bidir xcvr_bidir_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .b_in    (b_in),
    .ab_oe   (ab_oe),
    .ab_le   (ab_le),
    .ab_clk  (ab_clk),
    .ba_oe_n (ba_oe_n),
    .ba_le   (ba_le),
    .ba_clk  (ba_clk),
    .b_out   (b_out),
    .b_drive (b_drive),
    .a_out   (a_out),
    .a_drive (a_drive)
);

// File: tb/xcvr_bidir_test.sv
module xcvr_bidir_test;
    localparam int unsigned W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_oe = 1'b0, ab_le = 1'b0, ab_clk = 1'b0;
    logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0;
    logic [W-1:0] b_out, a_out;
    logic         b_drive, a_drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xcvr_bidir #(.W(W)) uut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
    );

    typedef struct {
        string        tag;
        logic [W-1:0] b_val;
        logic         b_en;
        logic [W-1:0] a_val;
        logic         a_en;
    } exp_t;

    exp_t exp_q[$];

    // Reference state of both paths
    logic [W-1:0] m_ab = '0, m_ba = '0;
    logic         p_ab = 1'b0, p_ba = 1'b0;

    task automatic step(input string tag, input logic r,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic aoe, input logic ale, input logic ack,
                        input logic boen, input logic ble, input logic bck);
        exp_t e;
        @(negedge clk);
        rst = r; a_in = a; b_in = b;
        ab_oe = aoe; ab_le = ale; ab_clk = ack;
        ba_oe_n = boen; ba_le = ble; ba_clk = bck;
        if (!r) begin
            e.tag   = tag;
            e.b_val = ale ? a : m_ab;
            e.b_en  = aoe;
            e.a_val = ble ? b : m_ba;
            e.a_en  = !boen;
            exp_q.push_back(e);
        end
        @(posedge clk);
        if (r) begin
            m_ab = '0; m_ba = '0; p_ab = 1'b0; p_ba = 1'b0;
        end else begin
            if (ale || (p_ab && !ack)) m_ab = a;
            if (ble || (p_ba && !bck)) m_ba = b;
            p_ab = ack; p_ba = bck;
        end
    endtask

    // Monitor: compares mid low phase, after drive settles
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (b_out !== e.b_val || b_drive !== e.b_en ||
                a_out !== e.a_val || a_drive !== e.a_en) begin
                errors++;
                $display("FAIL %s: b_out=%h b_drive=%b a_out=%h a_drive=%b expected %h %b %h %b",
                         e.tag, b_out, b_drive, a_out, a_drive,
                         e.b_val, e.b_en, e.a_val, e.a_en);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] x1, x2;
        // Reset, then R9: clock low after reset is not a fall, store reads zero
        step("R9", 1, 18'h3FFFF, 18'h3FFFF, 1, 0, 1, 0, 0, 1);
        step("R9", 1, 18'h3FFFF, 18'h3FFFF, 1, 0, 1, 0, 0, 1);
        step("R9", 0, 18'h2AAAA, 18'h15555, 1, 0, 0, 0, 0, 0);
        step("R9", 0, 18'h2AAAA, 18'h15555, 1, 0, 0, 0, 0, 0);

        // R1: transparent in both directions with several patterns
        step("R1", 0, 18'h00001, 18'h20000, 1, 1, 0, 0, 1, 0);
        step("R1", 0, 18'h3FFFF, 18'h00000, 1, 1, 1, 0, 1, 1);
        step("R1", 0, 18'h12345, 18'h2BCDE, 1, 1, 0, 0, 1, 0);

        // R5: close latch with no fall; last transparent word kept
        x1 = 18'h0F0F0;
        step("R5", 0, x1, 18'h11111, 1, 1, 0, 0, 1, 0);
        step("R5", 0, 18'h3C3C3, 18'h22222, 1, 0, 0, 0, 0, 0);
        step("R5", 0, 18'h00F00, 18'h33333, 1, 0, 0, 0, 0, 0);

        // R3: fall loads the word present at the low sample
        x2 = 18'h25A5A;
        step("R3", 0, 18'h11111, 18'h0AAAA, 1, 0, 1, 0, 0, 1);
        step("R3", 0, x2,        18'h05555, 1, 0, 0, 0, 0, 0);
        step("R3", 0, 18'h01010, 18'h3FFFF, 1, 0, 0, 0, 0, 0);

        // R4: rising path clock loads nothing
        step("R4", 0, 18'h3FFFF, 18'h00000, 1, 0, 1, 0, 0, 1);
        step("R4", 0, 18'h0000F, 18'h0000F, 1, 0, 1, 0, 0, 1);

        // R2: hold with moving data and steady clocks high
        step("R2", 0, 18'h1E1E1, 18'h0E0E0, 1, 0, 1, 0, 0, 1);
        step("R2", 0, 18'h21212, 18'h31313, 1, 0, 1, 0, 0, 1);

        // R6 and R7: enable polarities
        step("R6", 0, 18'h00000, 18'h00000, 0, 0, 1, 0, 0, 1);
        step("R7", 0, 18'h00000, 18'h00000, 1, 0, 1, 1, 0, 1);
        step("R7", 0, 18'h00000, 18'h00000, 0, 0, 1, 1, 0, 1);

        // R8: toggle A-to-B controls while B-to-A holds
        for (int i = 0; i < 12; i++)
            step("R8", 0, W'($urandom), 18'h3ABCD, i[0], i[1], i[2], 0, 0, 1);

        // Random phase over all controls
        for (int i = 0; i < 400; i++) begin
            logic [7:0] c;
            c = 8'($urandom);
            step("random", 0, W'($urandom), W'($urandom),
                 c[0], c[1] & c[6], c[2], c[3], c[4] & c[7], c[5]);
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule